// File: doc/BRIEF.md
# Variable product-term AND-OR array

This block is the programmable sum-of-products plane of a small PAL-style logic device. Twelve dedicated inputs and ten feedback lines from the macrocells form a 22-signal literal space. A fuse map chooses, for every product term and every input, whether the term uses the true literal, the complemented literal, or neither. Ten OR sums leave the plane for the macrocells. The sums have unequal sizes: two sums each of 8, 10, 12, 14 and 16 terms. The plane also produces one enable term per output and two shared terms, a synchronous-preset term and an asynchronous-reset term.

The fuse map is held in flops and loaded one 44-bit row at a time through a write port with an address, data and a write strobe. All outputs are combinational functions of the stored map and the current inputs. Reset clears every fuse. This is the erased condition, in which every term evaluates to 1. To switch an unused term off, software writes a row that selects both polarities of one input.

Top module: `pal_sop_array`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every fuse is 0 and `sum_o`, `oe_o`, `preset_o` and `areset_o` are all 1 for any input values.
- R2: In a row, bit 2i selects the true literal of input i and bit 2i+1 selects its complement. A term is the AND of its selected literals, and a row with no bits set evaluates to 1.
- R3: A row that selects both the true and the complement literal of any input evaluates to 0 for every input pattern.
- R4: Output k owns 8+2*floor(k/2) rows laid out back to back from row 0 in increasing k, so output 0 owns rows 0..7, output 2 owns rows 16..25 and output 9 owns rows 104..119. `sum_o[k]` is the OR of exactly those rows.
- R5: Row 120+k is the enable term of output k and drives `oe_o[k]`.
- R6: Row 130 drives `preset_o` and row 131 drives `areset_o`.
- R7: A write to an address of 132 or above changes no fuse.
- R8: With `wr_en` low no fuse changes, whatever `wr_addr` and `wr_data` carry.
- R9: Inputs 0..11 are `ded_i[0..11]` and inputs 12..21 are `fb_i[0..9]`.
- R10: A write with `wr_en` high takes effect at that rising clock edge, and the outputs reflect the new row right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse write port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Fuse row write strobe |
| wr_addr | input | 8 | Fuse row address |
| wr_data | input | 44 | Fuse row contents, two bits per input |
| ded_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals from the ten macrocells |
| sum_o | output | 10 | OR sums, one per output |
| oe_o | output | 10 | Enable product terms, one per output |
| preset_o | output | 1 | Shared synchronous-preset product term |
| areset_o | output | 1 | Shared asynchronous-reset product term |

## Verification
A fixed map is programmed with all other terms switched off. A table of input patterns then moves each programmed term through its true and false cases. This separates true from complement literals, dedicated inputs from feedback inputs, and the first and last rows of a sum group from rows that belong to a neighbouring output. Directed writes then probe the edges of the map. These cover a term with a literal clash, an erased row placed at the first row of the next output's group, out-of-range addresses, and a strobe held low while the address and data change. Each of these writes should move exactly one output bit or none. A final reset confirms that the erased, all-ones state returns.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;

  // Number of product terms owned by output k: pairs of outputs share a size.
  function automatic int unsigned terms_of(input int unsigned k,
                                           input int unsigned min_t,
                                           input int unsigned step);
    return min_t + step * (k / 2);
  endfunction

  // First row of output k's group: groups are packed in increasing k.
  function automatic int unsigned base_of(input int unsigned k,
                                          input int unsigned min_t,
                                          input int unsigned step);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += terms_of(j, min_t, step);
    return acc;
  endfunction

endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int unsigned ROWS   = 132,
  parameter int unsigned ROW_W  = 44,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [ROW_W-1:0]            wr_data,
  output logic [ROWS-1:0][ROW_W-1:0]  map_o
);
  logic [ROWS-1:0][ROW_W-1:0] map_q, map_d;
  logic                       addr_ok;

  assign addr_ok = ({1'b0, wr_addr} < (ADDR_W+1)'(ROWS));

  // next-state
  always_comb begin
    map_d = map_q;
    if (addr_ok) map_d[wr_addr] = wr_data;
  end

  // register, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    map_q <= '0;
    else if (wr_en) map_q <= map_d;
  end

  assign map_o = map_q;

  // R10: a legal write is visible in the row after the edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr_ok) |=> map_q[$past(wr_addr)] == $past(wr_data));

  // R7: out-of-range address leaves the map alone
  a_r7_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !addr_ok) |=> $stable(map_q));

  // R8: no strobe, no change
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(map_q));
endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int unsigned N_IN = 22
) (
  input  logic [2*N_IN-1:0] fuse_i,
  input  logic [N_IN-1:0]   x_i,
  output logic              term_o
);
  logic [N_IN-1:0] lit_ok;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_ok[i] = (~fuse_i[2*i] | x_i[i]) & (~fuse_i[2*i+1] | ~x_i[i]);
  end

  assign term_o = &lit_ok;
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
  import pal_sop_pkg::*;
#(
  parameter int unsigned N_DED  = 12,
  parameter int unsigned N_OUT  = 10,
  parameter int unsigned MIN_T  = 8,
  parameter int unsigned STEP_T = 2,
  localparam int unsigned N_IN    = N_DED + N_OUT,
  localparam int unsigned ROW_W   = 2 * N_IN,
  localparam int unsigned N_SUM   = base_of(N_OUT, MIN_T, STEP_T),
  localparam int unsigned OE_BASE = N_SUM,
  localparam int unsigned PRE_ROW = N_SUM + N_OUT,
  localparam int unsigned RST_ROW = PRE_ROW + 1,
  localparam int unsigned ROWS    = RST_ROW + 1,
  localparam int unsigned ADDR_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_OUT-1:0]  fb_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              preset_o,
  output logic              areset_o
);
  logic                       rst_sn;
  logic [ROWS-1:0][ROW_W-1:0] map;
  logic [ROWS-1:0]            term_vec;
  logic [N_IN-1:0]            x_vec;

  assign x_vec = {fb_i, ded_i};

  pal_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pal_fuse_store #(.ROWS(ROWS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_ni  (rst_sn),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .map_o   (map)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [N_IN-1:0] clash;

    pal_pterm #(.N_IN(N_IN)) u_pt (
      .fuse_i (map[r]),
      .x_i    (x_vec),
      .term_o (term_vec[r])
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_clash
      assign clash[i] = map[r][2*i] & map[r][2*i+1];
    end

    // R3: a term holding both literals of one input is dead
    a_r3_clash_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (|clash) |-> !term_vec[r]);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int unsigned B = base_of(k, MIN_T, STEP_T);
    localparam int unsigned C = terms_of(k, MIN_T, STEP_T);
    assign sum_o[k] = |term_vec[B +: C];
    assign oe_o[k]  = term_vec[OE_BASE + k];
  end

  assign preset_o = term_vec[PRE_ROW];
  assign areset_o = term_vec[RST_ROW];

  // R1: on leaving reset the plane is fully erased
  a_r1_erased_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sn) |-> (&sum_o && &oe_o && preset_o && areset_o));
endmodule

// File: tb/pal_sop_array_bench.sv
module pal_sop_array_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [43:0] wr_data;
  logic [11:0] ded_i;
  logic [9:0]  fb_i;
  logic [9:0]  sum_o, oe_o;
  logic        preset_o, areset_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pal_sop_array u_pal_sop_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ded_i(ded_i), .fb_i(fb_i), .sum_o(sum_o),
    .oe_o(oe_o), .preset_o(preset_o), .areset_o(areset_o)
  );

  // {ded, fb, sum, oe, preset, areset}
  localparam logic [43:0] VEC [8] = '{
    {12'h000, 10'h000, 10'h001, 10'h000, 1'b0, 1'b1},
    {12'h007, 10'h000, 10'h001, 10'h000, 1'b0, 1'b1},
    {12'h004, 10'h001, 10'h200, 10'h000, 1'b0, 1'b1},
    {12'h00C, 10'h000, 10'h004, 10'h000, 1'b0, 1'b1},
    {12'h00C, 10'h200, 10'h000, 10'h000, 1'b0, 1'b1},
    {12'h0F4, 10'h001, 10'h200, 10'h001, 1'b1, 1'b0},
    {12'h06F, 10'h3FF, 10'h201, 10'h000, 1'b1, 1'b1},
    {12'hF00, 10'h1FE, 10'h001, 10'h000, 1'b0, 1'b1}
  };

  localparam logic [43:0] DEAD = 44'h3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [43:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input logic [11:0] d, input logic [9:0] f);
    @(negedge clk);
    ded_i = d; fb_i = f;
    #1;
  endtask

  task automatic check_all(input string req, input logic [9:0] s, input logic [9:0] o,
                           input logic p, input logic r);
    chk(req, 32'(sum_o), 32'(s));
    chk(req, 32'(oe_o), 32'(o));
    chk(req, 32'(preset_o), 32'(p));
    chk(req, 32'(areset_o), 32'(r));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ded_i = 12'h5A5; fb_i = 10'h2C3;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset", 10'h3FF, 10'h3FF, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check_all("R1 after release", 10'h3FF, 10'h3FF, 1'b1, 1'b1);

    // switch every term off, then program a small map
    for (int r = 0; r < 132; r++) wr(8'(r), DEAD, 1'b1);
    apply(12'h000, 10'h000);
    check_all("R3 all dead", 10'h000, 10'h000, 1'b0, 1'b0);

    wr(8'd0,   44'h5, 1'b1);                          // R4: out0 first row, d0&d1
    wr(8'd7,   44'h20, 1'b1);                         // R4: out0 last row, !d2
    wr(8'd25,  (44'h1 << 6) | (44'h1 << 43), 1'b1);   // R4 out2 last row, d3 & !fb9
    wr(8'd119, 44'h1 << 24, 1'b1);                    // R9 out9 last row, fb0
    wr(8'd120, 44'h1 << 8, 1'b1);                     // R5 oe0 = d4
    wr(8'd130, (44'h1 << 10) | (44'h1 << 12), 1'b1);  // R6 preset = d5&d6
    wr(8'd131, 44'h1 << 15, 1'b1);                    // R6 areset = !d7

    for (int v = 0; v < 8; v++) begin
      apply(VEC[v][43:32], VEC[v][31:22]);
      check_all($sformatf("R2 R4 R5 R6 R9 vec%0d", v),
                VEC[v][21:12], VEC[v][11:2], VEC[v][1], VEC[v][0]);
    end

    // R7: out-of-range writes of an erased row change nothing
    wr(8'd132, 44'h0, 1'b1);
    wr(8'd255, 44'h0, 1'b1);
    apply(12'h004, 10'h000);
    check_all("R7 bad address", 10'h000, 10'h000, 1'b0, 1'b1);

    // R8: strobe low with an erased row aimed at out0
    wr(8'd1, 44'h0, 1'b0);
    apply(12'h004, 10'h000);
    chk("R8 idle write", 32'(sum_o), 32'h0);

    // R2/R4: erased row at out1 first row raises only sum bit 1
    wr(8'd8, 44'h0, 1'b1);
    apply(12'h004, 10'h000);
    chk("R4 R2 out1 first row", 32'(sum_o), 32'h002);

    // R3: row 0 gets d0 both polarities plus d1
    apply(12'h007, 10'h000);
    chk("R3 before clash", 32'(sum_o), 32'h003);
    wr(8'd0, 44'h7, 1'b1);
    apply(12'h007, 10'h000);
    chk("R3 clash row", 32'(sum_o), 32'h002);

    // R5/R10: oe9 = !fb9, seen right after the write edge
    @(negedge clk); ded_i = 12'h010; fb_i = 10'h000;
    wr_en = 1'b1; wr_addr = 8'd129; wr_data = 44'h1 << 43;
    #1;
    chk("R10 before edge", 32'(oe_o), 32'h001);
    @(posedge clk); #1;
    chk("R10 R5 after edge", 32'(oe_o), 32'h201);
    @(negedge clk); wr_en = 1'b0;

    // R1: reset erases the programmed map again
    rst_n = 1'b0;
    #1;
    check_all("R1 re-reset", 10'h3FF, 10'h3FF, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(12'h000, 10'h3FF);
    check_all("R1 erased after re-reset", 10'h3FF, 10'h3FF, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule